// File: doc/BRIEF.md
# Recirculating Serial Pattern Locator

The block searches a block of N data bits for every position at which a short target pattern begins. The data block is replayed continuously, one bit per clock, and the target is fed one bit per pass, so the target runs at roughly the data rate divided by N. A single agreement gate compares each data bit with the current target bit. An AND gate combines that result with a candidate flag read from an (N+1)-slot recirculating loop, and the AND output is written back into the loop. Because the loop is one slot longer than the data block, every pass lines each flag up with the data bit one position further along. After m passes a flag is still set only where all m target bits agreed in sequence.

A start pulse fills the loop with ones, so every position begins as a candidate. It also captures the target length m and clears the counters. Each pass lasts N+1 clocks. Once m passes are complete, the block spends one pass reading out. It raises a done pulse and presents the N surviving flags in slot order, each with its slot index. The cost is latency rather than gates: a search takes m(N+1)+N clocks.

Top module: `pattern_locator`

## Requirements
- R1: While reset is held and in the first cycle after it is released, match_o, match_vld_o and done_o are all 0.
- R2: A start pulse fills every loop slot with 1, clears the slot and pass counters, and captures m_i. The clock cycle right after the start pulse is cycle 0 of pass 0.
- R3: Cycle c after start (counting from 0) belongs to pass c/(N+1), slot c mod (N+1), and must carry data bit c mod N on data_i. The target bit for pass k is taken from tgt_bit_i in the slot-0 cycle of that pass, with tgt_vld_i = 1. When tgt_vld_i = 0 the last accepted target bit is held and tgt_bit_i has no effect.
- R4: In each cycle of a pass, the data bit agrees with the target bit exactly when the two are equal. The flag written back is that agreement ANDed with the flag read from the loop.
- R5: After m passes, the flag of slot j (0 ≤ j < N) is 1 exactly when data[(j+k) mod N] equals target[k] for every k < m. Every matching position is flagged, not only the first.
- R6: In pass m, done_o is 1 only in slot 0, and match_vld_o is 1 in slots 0..N-1 with slot_o = j and match_o = flag of slot j. Outside a readout, match_vld_o and match_o are 0 until the next start.
- R7: Target lengths up to 16 work, including m > N, where the pattern wraps around the data block more than once.
- R8: With m_i = 0, readout begins in the cycle right after the start pulse, and every flag reads 1.
- R9: A start pulse during a running search or a readout takes priority. The loop is refilled with ones and the new search proceeds as if no earlier search had run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse: refill loop, capture length |
| m_i | input | MW | Target length in bits (0..MAXM) |
| data_i | input | 1 | Serial replayed data bit |
| tgt_bit_i | input | 1 | Target bit for the current pass |
| tgt_vld_i | input | 1 | Strobe that accepts tgt_bit_i |
| match_o | output | 1 | Flag of the slot being read out |
| match_vld_o | output | 1 | Readout in progress |
| done_o | output | 1 | Pulse in the first readout cycle |
| slot_o | output | SW | Slot index during readout |

## Verification
The case that can collide is a new start pulse arriving in the same cycle as the done pulse of a previous search. In that cycle the readout would otherwise continue, and start must take over. The bench provokes this in two steps. It first runs a search whose target matches nowhere, so every flag is cleared, and it cuts that search off with a start in its done cycle. The follow-up search must then report its own expected set flags. Stale zeros left in the loop would show as missing matches, which separates a proper refill from a readout that kept running.

// File: rtl/ploc_pkg.sv
// Package: shared types of the serial pattern locator.
// Assumes: nothing beyond a standard SystemVerilog flow.
package ploc_pkg;

    // Sequencer phase: idle, comparison passes, or flag readout pass.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_READ = 2'd2
    } ploc_state_e;

endpackage

// File: rtl/ploc_compare_gate.sv
// Module: agreement gate plus AND with the recirculated candidate flag.
// Holds the last accepted target bit so that one strobe per pass is enough.
// Assumes: tgt_vld_i pulses in the first cycle of each comparison pass.
module ploc_compare_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic data_i,
    input  logic tgt_bit_i,
    input  logic tgt_vld_i,
    input  logic flag_i,
    output logic flag_o
);

    logic tgt_hold_q;
    logic tgt_eff;
    logic agree;

    // Capture the target bit whenever the strobe accepts one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_hold_q <= 1'b1;
        end else if (tgt_vld_i) begin
            tgt_hold_q <= tgt_bit_i;
        end
    end

    // Pick the fresh bit in the strobe cycle, the held bit otherwise.
    always_comb begin
        tgt_eff = tgt_vld_i ? tgt_bit_i : tgt_hold_q;
    end

    // Agreement of data and target, ANDed with the surviving flag.
    always_comb begin
        agree  = ~(data_i ^ tgt_eff);
        flag_o = agree & flag_i;
    end

endmodule

// File: rtl/ploc_recirc_loop.sv
// Module: recirculating flag store of DEPTH single-bit slots.
// The oldest slot is the tap. Load fills all slots with ones in one cycle.
// Assumes: DEPTH >= 2; load takes priority over shift.
module ploc_recirc_loop #(
    parameter int DEPTH = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_ones_i,
    input  logic shift_i,
    input  logic wr_bit_i,
    output logic tap_o
);

    logic [DEPTH-1:0] slot_q;

    // Stage 0 takes the written bit; every later stage takes its neighbour.
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        // One slot of the loop: clear on reset, fill on load, move on shift.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= 1'b0;
            end else if (load_ones_i) begin
                slot_q[g] <= 1'b1;
            end else if (shift_i) begin
                if (g == 0) begin
                    slot_q[g] <= wr_bit_i;
                end else begin
                    slot_q[g] <= slot_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    end

    // The tap is the slot written DEPTH cycles ago.
    always_comb begin
        tap_o = slot_q[DEPTH-1];
    end

endmodule

// File: rtl/ploc_sequencer.sv
// Module: slot and pass counters plus phase control of the locator.
// A pass lasts N+1 cycles. After m comparison passes, one readout pass of N cycles follows.
// Assumes: start_i has priority over all other activity.
module ploc_sequencer
    import ploc_pkg::*;
#(
    parameter int N  = 8,
    parameter int MW = 5,
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [MW-1:0] m_i,
    output logic          run_o,
    output logic          read_o,
    output logic [SW-1:0] slot_o
);

    localparam logic [SW-1:0] SLOT_LAST = SW'(N);
    localparam logic [SW-1:0] READ_LAST = SW'(N - 1);
    localparam logic [MW-1:0] PASS_ONE  = MW'(1);

    ploc_state_e   st_q;
    logic [SW-1:0] slot_q;
    logic [MW-1:0] pass_q;
    logic [MW-1:0] mlen_q;

    // Advance slot and pass counters and step between the phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            slot_q <= '0;
            pass_q <= '0;
            mlen_q <= '0;
        end else if (start_i) begin
            mlen_q <= m_i;
            pass_q <= '0;
            slot_q <= '0;
            st_q   <= (m_i == '0) ? ST_READ : ST_RUN;
        end else begin
            case (st_q)
                ST_RUN: begin
                    if (slot_q == SLOT_LAST) begin
                        slot_q <= '0;
                        pass_q <= pass_q + PASS_ONE;
                        if ((pass_q + PASS_ONE) == mlen_q) begin
                            st_q <= ST_READ;
                        end
                    end else begin
                        slot_q <= slot_q + 1'b1;
                    end
                end
                ST_READ: begin
                    if (slot_q == READ_LAST) begin
                        slot_q <= '0;
                        st_q   <= ST_IDLE;
                    end else begin
                        slot_q <= slot_q + 1'b1;
                    end
                end
                default: begin
                    slot_q <= '0;
                end
            endcase
        end
    end

    // Decode the phase for the datapath.
    always_comb begin
        run_o  = (st_q == ST_RUN);
        read_o = (st_q == ST_READ);
        slot_o = slot_q;
    end

endmodule

// File: rtl/pattern_locator.sv
// Module: top of the recirculating serial pattern locator.
// One agreement gate and one AND gate feed an (N+1)-slot flag loop, and a sequencer times the passes and the readout.
// Assumes: data replayed with bit c mod N in cycle c after start, and one target strobe per pass.
module pattern_locator #(
    parameter  int N    = 8,
    parameter  int MAXM = 16,
    localparam int MW   = $clog2(MAXM + 1),
    localparam int SW   = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [MW-1:0] m_i,
    input  logic          data_i,
    input  logic          tgt_bit_i,
    input  logic          tgt_vld_i,
    output logic          match_o,
    output logic          match_vld_o,
    output logic          done_o,
    output logic [SW-1:0] slot_o
);

    logic          run;
    logic          read;
    logic [SW-1:0] slot;
    logic          tap;
    logic          gate_flag;
    logic          wr_bit;
    logic          shift;

    ploc_sequencer #(.N(N), .MW(MW), .SW(SW)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .m_i     (m_i),
        .run_o   (run),
        .read_o  (read),
        .slot_o  (slot)
    );

    ploc_compare_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_i    (data_i),
        .tgt_bit_i (tgt_bit_i),
        .tgt_vld_i (tgt_vld_i),
        .flag_i    (tap),
        .flag_o    (gate_flag)
    );

    ploc_recirc_loop #(.DEPTH(N + 1)) u_loop (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_ones_i (start_i),
        .shift_i     (shift),
        .wr_bit_i    (wr_bit),
        .tap_o       (tap)
    );

    // Comparison passes write the gated flag; the readout pass recirculates it unchanged.
    always_comb begin
        shift  = run | read;
        wr_bit = run ? gate_flag : tap;
    end

    // Present the readout stream.
    always_comb begin
        match_vld_o = read;
        match_o     = read & tap;
        done_o      = read && (slot == '0);
        slot_o      = slot;
    end

endmodule

// File: rtl/ploc_checker.sv
// Module: property checker for the pattern locator, bound to the top.
// Assumes: synchronous active-low reset; properties are disabled while it is held.
module ploc_checker #(
    parameter int N  = 8,
    parameter int MW = 5,
    parameter int SW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [MW-1:0] m_i,
    input logic          match_o,
    input logic          match_vld_o,
    input logic          done_o,
    input logic [SW-1:0] slot_o
);

    p_done_at_slot0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (match_vld_o && slot_o == '0));

    p_match_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !match_vld_o |-> !match_o);

    p_slot_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        match_vld_o |-> (slot_o < SW'(N)));

    p_slot_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (match_vld_o && !done_o) |-> (slot_o == $past(slot_o) + 1'b1));

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !done_o);

    p_quiet_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && m_i != '0) |=> !match_vld_o);

    p_zero_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && m_i == '0) |=> done_o);

endmodule

bind pattern_locator ploc_checker #(.N(N), .MW(MW), .SW(SW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .m_i         (m_i),
    .match_o     (match_o),
    .match_vld_o (match_vld_o),
    .done_o      (done_o),
    .slot_o      (slot_o)
);

// File: tb/pattern_locator_tb.sv
module pattern_locator_tb;

    localparam int N    = 8;
    localparam int MAXM = 16;
    localparam int MW   = $clog2(MAXM + 1);
    localparam int SW   = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [MW-1:0] m_i = '0;
    logic          data_i = 1'b0;
    logic          tgt_bit_i = 1'b0;
    logic          tgt_vld_i = 1'b0;
    logic          match_o;
    logic          match_vld_o;
    logic          done_o;
    logic [SW-1:0] slot_o;

    int total = 0;
    int bad   = 0;
    bit d [N];
    bit t [MAXM];

    pattern_locator #(.N(N), .MAXM(MAXM)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .m_i(m_i),
        .data_i(data_i), .tgt_bit_i(tgt_bit_i), .tgt_vld_i(tgt_vld_i),
        .match_o(match_o), .match_vld_o(match_vld_o), .done_o(done_o),
        .slot_o(slot_o)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Expected flag of slot j after m passes, taken circularly.
    function automatic bit exp_flag(input int j, input int m);
        for (int k = 0; k < m; k++) begin
            if (d[(j + k) % N] != t[k]) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic void set_data(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) d[i] = v[i];
    endfunction

    function automatic void set_tgt(input logic [MAXM-1:0] v);
        for (int i = 0; i < MAXM; i++) t[i] = v[i];
    endfunction

    // Runs one search, called at a falling edge; stops early at cycle abort_at.
    task automatic run_search(input int m, input int abort_at, input string tag);
        start_i   = 1'b1;
        m_i       = MW'(m);
        tgt_vld_i = 1'b0;
        @(posedge clk);
        for (int c = 0; c < m * (N + 1) + N + 1; c++) begin
            int s;
            int p;
            @(negedge clk);
            if (c == abort_at) return;
            start_i = 1'b0;
            s = c % (N + 1);
            p = c / (N + 1);
            if (p == m && s < N) begin
                check(match_vld_o && int'(slot_o) == s, "R6 slot", int'(slot_o), s);
                check(done_o == (s == 0), "R6 done", done_o, (s == 0));
                check(match_o == exp_flag(s, m), tag, match_o, exp_flag(s, m));
            end else begin
                check(!match_vld_o && !done_o && !match_o, "R6 quiet",
                      {match_vld_o, done_o, match_o}, 0);
            end
            data_i = d[c % N];
            if (p < m && s == 0) begin
                tgt_vld_i = 1'b1;
                tgt_bit_i = t[p];
            end else begin
                tgt_vld_i = 1'b0;
                tgt_bit_i = (c % 3 == 1);
            end
        end
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check(!match_o && !match_vld_o && !done_o, "R1 in reset",
              {match_o, match_vld_o, done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!match_o && !match_vld_o && !done_o, "R1 after release",
              {match_o, match_vld_o, done_o}, 0);
    endtask

    task automatic t_single;
        set_data(8'b0100_1101);
        set_tgt(16'b0011);
        run_search(4, -1, "R4 R5 single");
    endtask

    task automatic t_multi;
        set_data(8'b0101_0101);
        set_tgt(16'b0101);
        run_search(3, -1, "R5 multiple");
    endtask

    task automatic t_none;
        set_data(8'b0000_0000);
        set_tgt(16'b1);
        run_search(1, -1, "R4 none");
    endtask

    task automatic t_wrap;
        set_data(8'b1100_0101);
        set_tgt(16'b1011);
        run_search(4, -1, "R3 R5 wrap");
    endtask

    task automatic t_long;
        set_data(8'b1001_0110);
        for (int k = 0; k < MAXM; k++) t[k] = d[(k + 3) % N];
        run_search(16, -1, "R7 long");
    endtask

    task automatic t_zero;
        set_data(8'b1010_0011);
        run_search(0, -1, "R8 zero");
    endtask

    task automatic t_restart;
        set_data(8'b0000_0000);
        set_tgt(16'b11111);
        run_search(5, 2 * (N + 1) + 3, "R9 aborted");
        set_data(8'b0110_1001);
        set_tgt(16'b101);
        run_search(3, -1, "R9 restart");
    endtask

    task automatic t_collide;
        set_data(8'b1111_1111);
        set_tgt(16'b00);
        run_search(2, 2 * (N + 1), "R2 collide first");
        set_data(8'b0011_0011);
        set_tgt(16'b0110);
        run_search(4, -1, "R2 collide second");
    endtask

    task automatic t_idle;
        for (int c = 0; c < N + 4; c++) begin
            @(negedge clk);
            check(!match_vld_o && !match_o && !done_o, "R6 idle",
                  {match_vld_o, match_o, done_o}, 0);
            data_i    = c[0];
            tgt_vld_i = c[1];
            tgt_bit_i = c[2];
        end
        tgt_vld_i = 1'b0;
    endtask

    initial begin
        t_reset();
        t_single();
        t_multi();
        t_none();
        t_wrap();
        t_long();
        t_zero();
        t_restart();
        t_collide();
        t_idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule